// File: doc/BRIEF.md
# Programmable Watchdog Timer with Output Steering

This block watches for a processor that has stopped servicing it. Software programs an 8-bit watchdog register on a simple strobe bus. The register holds a timeout, given as a 5-bit multiplier times a selectable time base, and a steering bit. The block has no time reference of its own: an external single-cycle strobe at 16 Hz supplies one, and the block divides it by four in stages to get the coarser time bases. The countdown starts again whenever the processor writes the watchdog register, and whenever the kick input changes level in either direction.

When the countdown expires, the block sets a sticky flag that a bus read of the flag register clears. The steering bit then chooses between two actions. The block either raises a held interrupt, which shares an output with an alarm interrupt and a frequency-test waveform, or it drives a fixed-length active-low reset pulse. A steered reset also clears the watchdog register, and it tells neighbouring logic to clear its enable bits. A power-down input disables the watchdog and clears its register.

Top module: `wdt_steer`

## Requirements
- R1: The watchdog register sits at bus address 7. Bit 7 is the steering bit, bits 6..2 are the multiplier m and bits 1..0 are the base code. A read of address 7 returns the register's current value, and the read data appears in the cycle after the read strobe. The register is 0 after reset.
- R2: With base code 00 (one 16 Hz strobe per step) and m > 0, the time-out occurs on exactly the m-th strobe after the register write that set it up.
- R3: Base codes 01, 10 and 11 use steps of 4, 16 and 64 strobes. The time-out occurs after more than (m-1) steps of strobes and no later than m steps of strobes.
- R4: A rising or a falling edge on the kick input reloads the countdown to m. Three cycles of settling are allowed for the edge to take effect.
- R5: Any write to the watchdog register reloads the countdown with the newly written m.
- R6: While m = 0, the watchdog never times out, whatever strobes arrive.
- R7: The flag register at address 0 reports the time-out flag in bit 7, and its other bits read 0. A read of address 0 returns the flag and then clears it.
- R8: With steering bit 0, a time-out drives irq_ft_o high and keeps it high until a register write whose m field is 0 (for example 0x00). Flag reads and further strobes do not release it.
- R9: With steering bit 1, a time-out makes rst_pulse_n_o low for exactly TREC_CYCLES clocks, pulses ctl_clear_o high for one clock and clears the watchdog register to 0. It does not raise irq_ft_o.
- R10: irq_ft_o is high whenever the watchdog interrupt or alarm_irq_i is active. Otherwise it follows ftest_wave_i while ftest_en_i is high, and it is 0 while ftest_en_i is low.
- R11: A cycle with pwr_dn_i high clears the watchdog register and the held interrupt. The watchdog then stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Single-cycle 16 Hz time-base strobe |
| kick_i | input | 1 | Asynchronous kick; each edge restarts the countdown |
| pwr_dn_i | input | 1 | Power-down: disables and clears the watchdog |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, registered |
| alarm_irq_i | input | 1 | Alarm interrupt sharing the output |
| ftest_en_i | input | 1 | Frequency-test enable |
| ftest_wave_i | input | 1 | Frequency-test waveform |
| irq_ft_o | output | 1 | Shared interrupt / frequency-test output, active high |
| rst_pulse_n_o | output | 1 | Active-low reset pulse |
| ctl_clear_o | output | 1 | One-cycle request to clear neighbouring enable bits |

## Verification
The hardest case to reach from the ports is a coarse-base time-out. The divide-by-four stages run freely, so the first step after a write can arrive anywhere from one strobe to a full step later, and the exact time-out strobe cannot be predicted. The stimulus picks random multipliers and base codes. It checks that the output stays quiet up to the lower edge of the allowed window and is asserted by its upper edge, so every prescaler phase left by earlier tests is accepted. The steered reset pulse is measured by a cycle-count monitor that runs while the test waits.

// File: rtl/wdt_steer.sv
module wdt_steer #(
  parameter int TREC_CYCLES = 16,
  parameter int ADDR_W      = 3,
  parameter int FLAG_ADDR   = 0,
  parameter int WDOG_ADDR   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16_i,
  input  logic              kick_i,
  input  logic              pwr_dn_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              alarm_irq_i,
  input  logic              ftest_en_i,
  input  logic              ftest_wave_i,
  output logic              irq_ft_o,
  output logic              rst_pulse_n_o,
  output logic              ctl_clear_o
);
  localparam int RW = $clog2(TREC_CYCLES + 1);
  localparam logic [ADDR_W-1:0] FADR = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] WADR = ADDR_W'(WDOG_ADDR);

  logic [7:0]    wd_reg;
  logic [4:0]    cnt;
  logic          expired, wd_irq_q, wdf_q;
  logic [RW-1:0] rcnt;
  logic [1:0]    pre16, pre4, pre1;
  logic [2:0]    ksync;
  logic          ctl_clear_q;

  wire       steer = wd_reg[7];
  wire [4:0] mult  = wd_reg[6:2];
  wire [1:0] res   = wd_reg[1:0];

  wire tick4  = tick16_i && (pre16 == 2'd3);
  wire tick1  = tick4    && (pre4  == 2'd3);
  wire tick_q = tick1    && (pre1  == 2'd3);

  logic tick_sel;
  always_comb begin
    case (res)
      2'd0:    tick_sel = tick16_i;
      2'd1:    tick_sel = tick4;
      2'd2:    tick_sel = tick1;
      default: tick_sel = tick_q;
    endcase
  end

  wire kick_edge = ksync[2] ^ ksync[1];
  wire wr_wd     = bus_wr_i && (bus_addr_i == WADR);
  wire rd_flag   = bus_rd_i && (bus_addr_i == FADR);
  wire armed     = (mult != 5'd0) && !expired;
  wire timeout   = tick_sel && armed && (cnt == 5'd1)
                   && !wr_wd && !kick_edge && !pwr_dn_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre16 <= '0;
      pre4  <= '0;
      pre1  <= '0;
    end else begin
      if (tick16_i) pre16 <= pre16 + 2'd1;
      if (tick4)    pre4  <= pre4 + 2'd1;
      if (tick1)    pre1  <= pre1 + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ksync <= '0;
    else        ksync <= {ksync[1:0], kick_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_reg   <= '0;
      cnt      <= '0;
      expired  <= 1'b0;
      wd_irq_q <= 1'b0;
    end else if (pwr_dn_i) begin
      wd_reg   <= '0;
      cnt      <= '0;
      expired  <= 1'b0;
      wd_irq_q <= 1'b0;
    end else if (wr_wd) begin
      wd_reg  <= bus_wdata_i;
      cnt     <= bus_wdata_i[6:2];
      expired <= 1'b0;
      if (bus_wdata_i[6:2] == 5'd0) wd_irq_q <= 1'b0;
    end else if (kick_edge) begin
      cnt     <= mult;
      expired <= 1'b0;
    end else if (timeout) begin
      expired <= 1'b1;
      cnt     <= '0;
      if (steer) wd_reg   <= '0;
      else       wd_irq_q <= 1'b1;
    end else if (tick_sel && armed) begin
      cnt <= cnt - 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wdf_q <= 1'b0;
    else if (timeout) wdf_q <= 1'b1;
    else if (rd_flag) wdf_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt        <= '0;
      ctl_clear_q <= 1'b0;
    end else begin
      ctl_clear_q <= timeout && steer;
      if (timeout && steer) rcnt <= RW'(TREC_CYCLES);
      else if (rcnt != '0)  rcnt <= rcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata_o <= '0;
    else if (bus_rd_i) begin
      if (bus_addr_i == FADR)      bus_rdata_o <= {wdf_q, 7'd0};
      else if (bus_addr_i == WADR) bus_rdata_o <= wd_reg;
      else                         bus_rdata_o <= '0;
    end else bus_rdata_o <= '0;
  end

  assign rst_pulse_n_o = (rcnt == '0);
  assign ctl_clear_o   = ctl_clear_q;
  assign irq_ft_o      = wd_irq_q || alarm_irq_i || (ftest_en_i && ftest_wave_i);
endmodule

// File: rtl/wdt_steer_chk.sv
module wdt_steer_chk #(
  parameter int TREC_CYCLES = 16,
  parameter int ADDR_W      = 3,
  parameter int FLAG_ADDR   = 0,
  parameter int WDOG_ADDR   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_dn_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [7:0]        bus_wdata_i,
  input logic              alarm_irq_i,
  input logic              irq_ft_o,
  input logic              rst_pulse_n_o,
  input logic              ctl_clear_o,
  input logic [7:0]        wd_reg,
  input logic              wd_irq_q,
  input logic              wdf_q,
  input logic              timeout
);
  localparam int LW = $clog2(TREC_CYCLES + 2) + 1;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_run <= '0;
    else if (rst_pulse_n_o) low_run <= '0;
    else                    low_run <= low_run + 1'b1;
  end

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == ADDR_W'(FLAG_ADDR) && !timeout) |=> !wdf_q);

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_irq_q && !pwr_dn_i &&
     !(bus_wr_i && bus_addr_i == ADDR_W'(WDOG_ADDR) && bus_wdata_i[6:2] == 5'd0))
    |=> wd_irq_q);

  p_no_timeout_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_reg[6:2] == 5'd0) |-> !timeout);

  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pulse_n_o |-> (low_run < LW'(TREC_CYCLES)));

  p_pulse_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pulse_n_o) |-> ctl_clear_o);

  p_clear_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear_o |=> !ctl_clear_o);

  p_power_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn_i |=> (wd_reg == 8'd0 && !wd_irq_q));

  p_irq_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_irq_i || wd_irq_q) |-> irq_ft_o);
endmodule

bind wdt_steer wdt_steer_chk #(
  .TREC_CYCLES(TREC_CYCLES), .ADDR_W(ADDR_W),
  .FLAG_ADDR(FLAG_ADDR), .WDOG_ADDR(WDOG_ADDR)
) chk_i (.*);

// File: tb/wdt_steer_tb_top.sv
module wdt_steer_tb_top;
  localparam int TREC = 16;

  logic clk = 0, rst_n = 0;
  logic tick16 = 0, kick = 0, pwr_dn = 0;
  logic [2:0] addr = 0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic alarm = 0, ft_en = 0, ft_wave = 0;
  logic irq_ft, rst_pn, ctl_clr;

  int n_tests = 0, n_fail = 0;
  int low_cnt = 0, clr_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdt_steer #(.TREC_CYCLES(TREC)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick16_i(tick16), .kick_i(kick), .pwr_dn_i(pwr_dn),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .alarm_irq_i(alarm), .ftest_en_i(ft_en),
    .ftest_wave_i(ft_wave), .irq_ft_o(irq_ft), .rst_pulse_n_o(rst_pn),
    .ctl_clear_o(ctl_clr));

  always @(negedge clk) begin
    if (!rst_pn) low_cnt++;
    if (ctl_clr) clr_cnt++;
  end

  function automatic int step_of(int r);
    case (r)
      0: return 1;
      1: return 4;
      2: return 16;
      default: return 64;
    endcase
  endfunction

  function automatic logic [7:0] enc(bit st, int m, int r);
    return {st, 5'(m), 2'(r)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick16 = 1;
      @(negedge clk) tick16 = 0;
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk) begin addr = a; wdata = d; wr = 1; end
    @(negedge clk) wr = 0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [7:0] d);
    @(negedge clk) begin addr = a; rd = 1; end
    @(negedge clk) rd = 0;
    d = rdata;
  endtask

  task automatic clean();
    logic [7:0] d;
    bus_write(3'd7, 8'h00);
    bus_read(3'd0, d);
  endtask

  task automatic toggle_kick();
    @(negedge clk) kick = ~kick;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(190000 * 10);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    bus_read(3'd7, d);  check(d == 8'h00, "R1 reset reg", d, 0);
    bus_read(3'd0, d);  check(d == 8'h00, "R7 reset flag", d, 0);
    check(rst_pn == 1 && irq_ft == 0, "R9 reset outputs", {rst_pn, irq_ft}, 2);

    bus_write(3'd7, 8'h5B);
    bus_read(3'd7, d);  check(d == 8'h5B, "R1 readback", d, 8'h5B);
    clean();

    bus_write(3'd7, enc(0, 3, 0));
    tick(2);  check(irq_ft == 0, "R2 before timeout", irq_ft, 0);
    tick(1);  check(irq_ft == 1, "R2 at timeout", irq_ft, 1);
    bus_read(3'd0, d);  check(d == 8'h80, "R7 flag set", d, 8'h80);
    bus_read(3'd0, d);  check(d == 8'h00, "R7 flag cleared", d, 0);
    tick(5);  check(irq_ft == 1, "R8 irq held", irq_ft, 1);
    bus_write(3'd7, 8'h00);
    check(irq_ft == 0, "R8 release on zero write", irq_ft, 0);

    for (int e = 0; e < 2; e++) begin
      clean();
      bus_write(3'd7, enc(0, 4, 0));
      tick(3);
      toggle_kick();
      tick(3);  check(irq_ft == 0, "R4 kick restart", irq_ft, 0);
      tick(1);  check(irq_ft == 1, "R4 timeout after kick", irq_ft, 1);
    end
    clean();

    bus_write(3'd7, enc(0, 4, 0));
    tick(3);
    bus_write(3'd7, enc(0, 4, 0));
    tick(3);  check(irq_ft == 0, "R5 write restart", irq_ft, 0);
    tick(1);  check(irq_ft == 1, "R5 timeout after rewrite", irq_ft, 1);
    clean();

    bus_write(3'd7, 8'h03);
    tick(200);
    check(irq_ft == 0, "R6 disabled no irq", irq_ft, 0);
    bus_read(3'd0, d);  check(d == 8'h00, "R6 disabled no flag", d, 0);
    clean();

    low_cnt = 0; clr_cnt = 0;
    bus_write(3'd7, enc(1, 2, 0));
    tick(1);  check(rst_pn == 1, "R9 no early pulse", rst_pn, 1);
    tick(1);
    repeat (TREC + 4) @(negedge clk);
    check(low_cnt == TREC, "R9 pulse length", low_cnt, TREC);
    check(clr_cnt == 1, "R9 clear strobe", clr_cnt, 1);
    check(irq_ft == 0, "R9 no irq", irq_ft, 0);
    bus_read(3'd7, d);  check(d == 8'h00, "R9 reg cleared", d, 0);
    bus_read(3'd0, d);  check(d == 8'h80, "R9 flag set", d, 8'h80);

    @(negedge clk) begin alarm = 1; ft_en = 1; ft_wave = 0; end
    #1 check(irq_ft == 1, "R10 alarm over ftest", irq_ft, 1);
    @(negedge clk) alarm = 0;
    #1 check(irq_ft == 0, "R10 ftest low", irq_ft, 0);
    @(negedge clk) ft_wave = 1;
    #1 check(irq_ft == 1, "R10 ftest high", irq_ft, 1);
    @(negedge clk) ft_en = 0;
    #1 check(irq_ft == 0, "R10 ftest off", irq_ft, 0);
    @(negedge clk) begin ft_en = 1; ft_wave = 0; end
    bus_write(3'd7, enc(0, 1, 0));
    tick(1);  check(irq_ft == 1, "R10 watchdog over ftest", irq_ft, 1);
    @(negedge clk) ft_en = 0;
    clean();

    bus_write(3'd7, enc(0, 4, 0));
    tick(3);
    @(negedge clk) pwr_dn = 1;
    @(negedge clk) pwr_dn = 0;
    bus_read(3'd7, d);  check(d == 8'h00, "R11 reg cleared", d, 0);
    tick(10); check(irq_ft == 0, "R11 disabled", irq_ft, 0);
    clean();

    for (int k = 0; k < 10; k++) begin
      int m = 1 + int'($urandom_range(30, 0));
      int r = int'($urandom_range(3, 0));
      int s = step_of(r);
      int lo = (m - 1) * s + 1;
      int hi = m * s;
      clean();
      bus_write(3'd7, enc(0, m, r));
      tick(lo - 1);
      check(irq_ft == 0, "R3 window low", irq_ft, 0);
      tick(hi - lo + 1);
      check(irq_ft == 1, "R3 window high", irq_ft, 1);
      bus_read(3'd0, d);  check(d == 8'h80, "R3 flag", d, 8'h80);
    end
    clean();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule